// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an up-counter peripheral with three ways of counting, selected by a control register. In timer mode it counts ticks of an internal clock divided by a power-of-two prescaler. In event mode it counts edges on an external input pin, with a choice of rising or falling edge and no prescaling. In pulse-width mode it arms when enabled, starts counting prescaled ticks when the pin leaves its idle level, stops when the pin returns, and then clears its own run bit so that the measured width stays readable.

When the counter passes its all-ones value it reloads from a preload register, keeps counting and raises a one-cycle interrupt request. An interrupt-enable input masks that request. Software reaches the block through a simple register write and read port. The external pin is synchronized inside the block.

Top module: `tmr_evt_cnt`

## Requirements
- R1: After reset the control register, preload register, counter and irq are all 0.
- R2: Register select 0 is control, 1 is preload, 2 is the counter (read only) and 3 reads 0. Control bit 5 always reads 0. Writing the preload while the run bit (control bit 4) is 0 also loads the counter. Writing it while the run bit is 1 leaves the counter alone.
- R3: Timer mode is control bits 7..6 = 10 with the run bit set. The counter advances once every 2^N cycles, where N is control bits 2..0.
- R4: Event mode is bits 7..6 = 01 with the run bit set. The counter advances once per synchronized pin edge: rising when control bit 3 is 0 and falling when it is 1. The prescaler field has no effect, and a level held steady gives no further counts.
- R5: An advance from all ones loads the preload value. In that case irq is 1 for the following cycle when irq_en is 1.
- R6: With irq_en at 0 an overflow still reloads, but irq stays 0.
- R7: Pulse-width mode is bits 7..6 = 11, with control bit 3 = 0. Setting the run bit only arms the counter. After a falling pin edge it counts prescaled ticks. On the following rising edge it stops, holds its count and clears the run bit.
- R8: Pulse-width mode with control bit 3 = 1 behaves the same way, with the polarities swapped: counting starts on a rising edge and stops on a falling edge.
- R9: With mode 00, or with the run bit at 0, the counter holds.
- R10: In a cycle that writes the control register, the counter does not advance. The write also restarts the prescaler and drops any pulse measurement in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for writing |
| wr_data | input | WIDTH | Write data |
| rd_sel | input | 2 | Register selected for reading |
| rd_data | output | WIDTH | Read data (combinational) |
| tmr_pin | input | 1 | External timer pin, asynchronous |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-cycle interrupt request per overflow |

## Verification
The bench uses the default parameters: WIDTH = 8 and RATE_BITS = 3. Overflow and reload are therefore reached within a few dozen cycles by preloading values near 255. The bench sweeps the prescaler rates 0, 1, 2 and 7 over the 7-bit divider. Together these cover every-cycle counting, back-to-back overflow and the widest division that event mode must ignore. Pulses of differing widths in both polarities, as well as control writes made in the middle of a measurement, exercise the arm, start, stop and self-clearing behaviour.

// File: rtl/tmr_evt_cnt.sv
module tmr_evt_cnt #(
  parameter int WIDTH     = 8,
  parameter int RATE_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  input  logic             tmr_pin,
  input  logic             irq_en,
  output logic             irq
);
  localparam int PSC_W = (1 << RATE_BITS) - 1;
  localparam logic [1:0] MODE_EVT = 2'b01;
  localparam logic [1:0] MODE_TMR = 2'b10;
  localparam logic [1:0] MODE_PW  = 2'b11;

  logic [7:0]           ctrl_q;
  logic [WIDTH-1:0]     pre_q, cnt_q;
  logic [PSC_W-1:0]     psc_q;
  logic                 sy1_q, sy2_q, sy3_q;
  logic                 pw_act_q;

  wire [1:0]           mode     = ctrl_q[7:6];
  wire                 run      = ctrl_q[4];
  wire                 edge_sel = ctrl_q[3];
  wire [RATE_BITS-1:0] rate     = ctrl_q[RATE_BITS-1:0];

  wire wr_ctrl = wr_en && (wr_sel == 2'd0);
  wire wr_pre  = wr_en && (wr_sel == 2'd1);

  wire pin_rise = sy2_q & ~sy3_q;
  wire pin_fall = ~sy2_q & sy3_q;
  wire evt_hit  = edge_sel ? pin_fall : pin_rise;
  wire pw_start = edge_sel ? pin_rise : pin_fall;
  wire pw_end   = edge_sel ? pin_fall : pin_rise;

  wire [PSC_W-1:0] psc_mask = ~({PSC_W{1'b1}} << rate);
  wire tick = &(psc_q | ~psc_mask);

  wire gate    = (mode == MODE_TMR && run) || (mode == MODE_PW && pw_act_q);
  wire pw_stop = (mode == MODE_PW) && pw_act_q && pw_end;
  wire inc     = !wr_ctrl && (((mode == MODE_EVT) && run && evt_hit) ||
                              (gate && tick && !pw_stop));
  wire ovf     = inc && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= 1'b0; sy2_q <= 1'b0; sy3_q <= 1'b0;
    end else begin
      sy1_q <= tmr_pin; sy2_q <= sy1_q; sy3_q <= sy2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      psc_q    <= '0;
      pw_act_q <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q   <= {wr_data[7:6], 1'b0, wr_data[4:0]};
      psc_q    <= '0;
      pw_act_q <= 1'b0;
    end else begin
      psc_q <= gate ? psc_q + 1'b1 : '0;
      if (pw_stop) begin
        ctrl_q[4] <= 1'b0;
        pw_act_q  <= 1'b0;
      end else if (mode == MODE_PW && run && !pw_act_q && pw_start) begin
        pw_act_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_pre) pre_q <= wr_data;
      if (inc) cnt_q <= ovf ? pre_q : cnt_q + 1'b1;
      else if (wr_pre && !run) cnt_q <= wr_data;
      irq <= ovf && irq_en;
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = WIDTH'(ctrl_q);
      2'd1:    rd_data = pre_q;
      2'd2:    rd_data = cnt_q;
      default: rd_data = '0;
    endcase
  end

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));
  assert_reload_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == $past(pre_q)));
  assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(cnt_q));
  assert_timer_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TMR && run && !wr_en && !tick) |=> $stable(cnt_q));
  assert_event_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_EVT && run && !wr_en && !evt_hit) |=> $stable(cnt_q));
  assert_pw_autoclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && !$past(wr_en)) |-> $past(mode == MODE_PW && pw_act_q));
  assert_ctrl_write_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> $stable(cnt_q));
endmodule

// File: tb/tmr_evt_cnt_tb_top.sv
`timescale 1ns/1ps
module tmr_evt_cnt_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, tmr_pin = 0, irq_en = 1;
  logic [1:0] wr_sel = 0, rd_sel = 2;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tmr_evt_cnt #(.WIDTH(8), .RATE_BITS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tmr_pin(tmr_pin), .irq_en(irq_en), .irq(irq));

  int m_ctrl, m_pre, m_cnt, m_psc, m_s1, m_s2, m_s3, m_act, m_irq;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_read(input int sel);
    case (sel)
      0: return m_ctrl;
      1: return m_pre;
      2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pre = 0; m_cnt = 0; m_psc = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_act = 0; m_irq = 0;
    end else begin
      int mode, run, esel, n, rise, fall, tick, gate, adv, div;
      mode = (m_ctrl >> 6) & 3; run = (m_ctrl >> 4) & 1; esel = (m_ctrl >> 3) & 1;
      n = m_ctrl & 7; div = 1 << n;
      rise = (m_s2 == 1 && m_s3 == 0); fall = (m_s2 == 0 && m_s3 == 1);
      tick = ((m_psc % div) == div - 1);
      adv = 0;
      if (wr_en && wr_sel == 0) begin
        m_ctrl = wr_data & 8'hDF; m_act = 0; m_psc = 0;
      end else begin
        gate = (mode == 2 && run) || (mode == 3 && m_act);
        m_psc = gate ? (m_psc + 1) % 128 : 0;
        if (mode == 1 && run && (esel ? fall : rise)) adv = 1;
        if (mode == 2 && run && tick) adv = 1;
        if (mode == 3) begin
          if (m_act) begin
            if (esel ? fall : rise) begin m_act = 0; m_ctrl = m_ctrl & 8'hEF; end
            else if (tick) adv = 1;
          end else if (run && (esel ? rise : fall)) m_act = 1;
        end
      end
      m_irq = 0;
      if (adv) begin
        if (m_cnt == 255) begin m_cnt = m_pre; m_irq = irq_en; end
        else m_cnt = m_cnt + 1;
      end else if (wr_en && wr_sel == 1 && !run) m_cnt = wr_data;
      if (wr_en && wr_sel == 1) m_pre = wr_data;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = tmr_pin;
    end
  end

  always @(posedge clk) begin
    #1;
    chk({cur_req, " rd_data"}, rd_data, m_read(rd_sel));
    chk({cur_req, " irq"}, irq, m_irq);
  end

  task automatic wr(input int sel, input int d);
    @(negedge clk); wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic rdx(input int sel, output int v);
    @(negedge clk); rd_sel = 2'(sel); #1 v = rd_data; rd_sel = 2;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, held;
    idle(3); rst_n = 1; idle(2);
    cur_req = "R1";
    for (int s = 0; s < 4; s++) begin rdx(s, v); chk("R1 reset value", v, 0); end
    chk("R1 irq", irq, 0);

    cur_req = "R2";
    wr(0, 8'h27); rdx(0, v); chk("R2 bit5 reads 0", v, 8'h07);
    wr(1, 8'h5A); rdx(2, v); chk("R2 preload loads stopped counter", v, 8'h5A);
    rdx(3, v); chk("R2 select 3 reads 0", v, 0);

    cur_req = "R3";
    wr(1, 8'hF0); wr(0, 8'h92); idle(90);
    wr(0, 8'h90); idle(40);
    wr(1, 8'h11); rdx(1, v); chk("R2 preload written while running", v, 8'h11);

    cur_req = "R6";
    irq_en = 0; wr(0, 0); wr(1, 8'hFE); wr(0, 8'h90); idle(12); irq_en = 1;
    cur_req = "R5";
    wr(0, 0); wr(1, 8'hFF); wr(0, 8'h90); idle(6);

    cur_req = "R9";
    wr(0, 8'h10); rdx(2, held); idle(20); rdx(2, v); chk("R9 mode 00 holds", v, held);
    wr(0, 8'hA0); idle(20); rdx(2, v); chk("R9 run 0 holds", v, held);

    cur_req = "R4";
    wr(0, 0); wr(1, 8'hF8); wr(0, 8'h57);
    for (int i = 0; i < 12; i++) begin tmr_pin = 1; idle(3 + i % 3); tmr_pin = 0; idle(2 + i % 4); end
    tmr_pin = 1; idle(30); tmr_pin = 0; idle(5);
    wr(0, 8'h5F);
    for (int i = 0; i < 10; i++) begin tmr_pin = 1; idle(4); tmr_pin = 0; idle(1 + i % 5); end
    idle(6);

    cur_req = "R7";
    tmr_pin = 1; idle(5);
    wr(0, 0); wr(1, 0); wr(0, 8'hD1); idle(10);
    rdx(2, v); chk("R7 armed does not count", v, 0);
    tmr_pin = 0; idle(30); tmr_pin = 1; idle(10);
    rdx(0, v); chk("R7 run bit self-cleared", v & 8'h10, 0);
    rdx(2, held); idle(10); rdx(2, v); chk("R7 count held", v, held);
    chk("R7 count nonzero", held != 0, 1);

    cur_req = "R8";
    tmr_pin = 0; idle(5);
    wr(1, 8'hF0); wr(0, 8'hD8); idle(6);
    tmr_pin = 1; idle(25); tmr_pin = 0; idle(8);
    rdx(0, v); chk("R8 run bit self-cleared", v & 8'h10, 0);

    cur_req = "R10";
    tmr_pin = 1; idle(5);
    wr(1, 0); wr(0, 8'hD0); idle(4);
    tmr_pin = 0; idle(10);
    wr(0, 8'hD0); rdx(2, held); idle(15); rdx(2, v); chk("R10 measurement dropped", v, held);
    tmr_pin = 1; idle(5);
    wr(0, 0); wr(1, 8'h40); wr(0, 8'h91); idle(3);
    for (int i = 0; i < 6; i++) begin wr(0, 8'h91); end
    idle(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule